// File: doc/BRIEF.md
# Synchronous Burst SRAM with Line Counter

This block is the data store of a processor second-level cache: a clocked single-port SRAM whose words are 72 bits wide, made of eight 9-bit lanes. Each lane holds a data byte and its parity bit. The host does not present an address on every beat. It pulses an active-low address strobe once to load the start of a burst. After that, an active-low advance input steps an internal counter through the rest of a four-word cache line. The counter wraps inside the aligned line, so a burst can start at any word of the line.

Writes need no timed write pulse. Data and the eight active-low lane enables are captured on the rising clock edge, at the word the address register holds before that edge. Reads are flow-through: the output shows the word at the registered address combinationally, in the same cycle the register changes, with no output register. The output bus is driven only while the active-low output enable is asserted, no lane write is requested and reset is released. Otherwise it is high-impedance. A separate flag reports when the drivers are on.

The word count is the parameter `DEPTH`, and the address width is derived from it. The default is kept small so the model elaborates quickly. A cache build sets `DEPTH` to 65536.

Top module: `burst_sram`

## Requirements
- R1: A rising edge with `strobe_n` low loads `addr` into the address register.
- R2: A rising edge with `strobe_n` high and `advance_n` low adds one to the two low address bits, modulo 4, and keeps every higher bit. Starting at line offset o, the beats visit o, o+1, o+2, o+3 (mod 4) and then return to o.
- R3: When `strobe_n` and `advance_n` are both low on the same edge, the new address from `addr` is loaded and no step takes place.
- R4: An edge with both `strobe_n` and `advance_n` high leaves the address register unchanged, so the same word can be read or written again.
- R5: Lane i is bits [9i+8:9i] of `din`, `q` and the stored word. On a rising edge, each lane whose `we_n[i]` is 0 is written from `din`. Lanes whose enable is 1 keep their contents.
- R6: A write uses the address held before the edge, including on an edge that also loads a new address or steps the counter.
- R7: While `q_drive` is 1, `q` equals the stored word at the current registered address, in the same cycle the register takes that address.
- R8: `q_drive` is 1 only when `rst_n` is 1, `oe_n` is 0 and all `we_n` bits are 1. When `q_drive` is 0, `q` is high-impedance.
- R9: Asserting reset clears the address register to 0 and keeps the output undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Active-low address strobe; loads `addr` |
| advance_n | input | 1 | Active-low burst step enable |
| addr | input | $clog2(DEPTH) | Burst start word address |
| we_n | input | 8 | Active-low lane write enables |
| oe_n | input | 1 | Active-low output enable |
| din | input | 72 | Write data, eight 9-bit lanes |
| q | output | 72 | Flow-through read data, high-impedance when not driven |
| q_drive | output | 1 | High while the `q` drivers are on |

## Verification
The bench first fills a small array with full-word bursts. It then starts a read burst at every offset of every line and runs five beats. This separates a correct wrap inside the line from a counter that carries into the upper bits or returns to offset 0. All 256 lane-enable masks are written over one word and read back. That sweep tells apart lane slicing, lane polarity and lane-order errors. Further cycles cover a strobe and an advance on the same edge, hold cycles, writes that coincide with a strobe, output-enable gating, and the first write after reset. Every cycle compares `q` with a reference array that the bench updates from the requirements, so a read that arrives one cycle late shows up as a mismatch.

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 8,
  parameter int LANE_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * LANE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n,
  input  logic          advance_n,
  input  logic [AW-1:0] addr,
  input  logic [LANES-1:0] we_n,
  input  logic          oe_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] q,
  output logic          q_drive
);
  localparam int LB = 2;

  logic [AW-1:0] areg;
  logic [DW-1:0] mem [DEPTH];
  logic          writing;

  assign writing = ~&we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      areg <= '0;
    else if (!strobe_n)
      areg <= addr;
    else if (!advance_n)
      areg <= {areg[AW-1:LB], areg[LB-1:0] + LB'(1)};
  end

  always_ff @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < LANES; i++)
        if (!we_n[i])
          mem[areg][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
    end
  end

  assign q_drive = rst_n && !oe_n && !writing;
  assign q       = q_drive ? mem[areg] : 'z;
endmodule

module burst_sram_chk #(
  parameter int AW = 10,
  parameter int LANES = 8,
  parameter int DW = 72
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_n,
  input logic          advance_n,
  input logic [AW-1:0] addr,
  input logic [LANES-1:0] we_n,
  input logic          oe_n,
  input logic [DW-1:0] din,
  input logic [DW-1:0] q,
  input logic          q_drive,
  input logic [AW-1:0] areg
);
  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |=> areg == $past(addr));

  a_r2_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && !advance_n) |=>
      (areg[1:0] == 2'($past(areg[1:0]) + 2'd1)) && (areg[AW-1:2] == $past(areg[AW-1:2])));

  a_r3_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !advance_n) |=> areg == $past(addr));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && advance_n) |=> $stable(areg));

  a_r6_full_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n == '0 && strobe_n && advance_n) |=> (!q_drive || q == $past(din)));

  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n || !(&we_n)) |-> !q_drive);

  always_comb begin
    if (!rst_n) a_r9_reset_quiet: assert (!q_drive);
  end
endmodule

bind burst_sram burst_sram_chk #(.AW(AW), .LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .advance_n(advance_n),
  .addr(addr), .we_n(we_n), .oe_n(oe_n), .din(din), .q(q),
  .q_drive(q_drive), .areg(areg)
);

// File: tb/burst_sram_bench.sv
module burst_sram_bench;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int DW = 72;

  logic clk = 0;
  logic rst_n = 0;
  logic strobe_n = 1, advance_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] we_n = 8'hFF;
  logic [DW-1:0] din = '0;
  wire  [DW-1:0] q;
  wire  q_drive;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [7:0]    known   [DEPTH];
  logic [AW-1:0] ma = '0;

  burst_sram #(.DEPTH(DEPTH)) u_burst_sram (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .advance_n(advance_n),
    .addr(addr), .we_n(we_n), .oe_n(oe_n), .din(din), .q(q), .q_drive(q_drive)
  );

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [31:0] h;
    h = 32'(a) * 32'h9E3779B1 ^ 32'(salt);
    return {8'(a + salt), h, ~h ^ 32'(a << 8)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic s_n, a_n, input logic [AW-1:0] ad,
                     input logic [7:0] w_n, input logic o_n,
                     input logic [DW-1:0] d, input string tag);
    bit exp_drv;
    @(negedge clk);
    strobe_n = s_n; advance_n = a_n; addr = ad; we_n = w_n; oe_n = o_n; din = d;
    @(posedge clk);
    if (rst_n) begin
      for (int i = 0; i < 8; i++)
        if (!w_n[i]) begin
          ref_mem[ma][i*9 +: 9] = d[i*9 +: 9];
          known[ma][i] = 1'b1;
        end
      if (!s_n) ma = ad;
      else if (!a_n) ma = {ma[AW-1:2], ma[1:0] + 2'd1};
    end else ma = '0;
    #1;
    exp_drv = rst_n && !o_n && (&w_n);
    chk(q_drive == exp_drv, {tag, " drive"}, DW'(q_drive), DW'(exp_drv));
    if (exp_drv && (&known[ma]))
      chk(q == ref_mem[ma], tag, q, ref_mem[ma]);
  endtask

  initial begin
    #100000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = '0; known[i] = '0; end
    // R9: outputs stay undriven while reset is held, even with oe_n low
    cyc(1, 1, '0, 8'hFF, 0, '0, "R9");
    cyc(0, 0, 6'd9, 8'hFF, 0, '0, "R9");
    rst_n = 1;
    // R9: the first write after reset lands at word 0
    cyc(1, 1, '0, 8'h00, 0, pat(0, 77), "R9");
    cyc(0, 1, 6'd0, 8'hFF, 0, '0, "R9");
    // fill every line with full-word burst writes (R1, R2, R5)
    for (int ln = 0; ln < DEPTH/4; ln++) begin
      cyc(0, 1, AW'(ln*4), 8'hFF, 1, '0, "R1");
      for (int b = 0; b < 4; b++)
        cyc(1, 0, '0, 8'h00, 0, pat(ln*4 + b, 1), "R2");
    end
    // R2/R7: bursts from every offset of every line, including the wrap back
    for (int a = 0; a < DEPTH; a++) begin
      cyc(0, 1, AW'(a), 8'hFF, 0, '0, "R7");
      for (int k = 0; k < 4; k++)
        cyc(1, 0, '0, 8'hFF, 0, '0, "R2");
    end
    // R3: strobe and advance on the same edge
    cyc(1, 0, '0, 8'hFF, 0, '0, "R3");
    cyc(0, 0, 6'd22, 8'hFF, 0, '0, "R3");
    cyc(0, 0, 6'd47, 8'hFF, 0, '0, "R3");
    // R4: holding cycles keep the word
    for (int k = 0; k < 3; k++) cyc(1, 1, '0, 8'hFF, 0, '0, "R4");
    // R5: every lane mask over one word
    cyc(0, 1, 6'd37, 8'hFF, 0, '0, "R5");
    for (int m = 0; m < 256; m++) begin
      cyc(1, 1, '0, ~8'(m), 0, pat(m, 5), "R5");
      cyc(1, 1, '0, 8'hFF, 0, '0, "R5");
    end
    // R6: write on a strobe edge goes to the old address
    cyc(0, 1, 6'd50, 8'hFF, 0, '0, "R6");
    cyc(0, 1, 6'd13, 8'h00, 0, pat(50, 99), "R6");
    cyc(0, 1, 6'd50, 8'hFF, 0, '0, "R6");
    cyc(0, 1, 6'd13, 8'hFF, 0, '0, "R6");
    // R6: write on an advance edge goes to the old address
    cyc(1, 0, '0, 8'h0F, 0, pat(13, 3), "R6");
    cyc(0, 1, 6'd13, 8'hFF, 0, '0, "R6");
    // R8: output enable and write gating
    cyc(1, 1, '0, 8'hFF, 1, '0, "R8");
    cyc(1, 1, '0, 8'hFE, 0, pat(7, 7), "R8");
    cyc(1, 1, '0, 8'hFF, 0, '0, "R8");
    // R9: reset in the middle returns the address to 0
    cyc(0, 1, 6'd33, 8'hFF, 0, '0, "R9");
    @(negedge clk); rst_n = 0;
    cyc(1, 1, '0, 8'hFF, 0, '0, "R9");
    rst_n = 1;
    cyc(1, 1, '0, 8'hFF, 0, '0, "R9");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule